// File: doc/BRIEF.md
# Package Low Power Coordinator

This block decides the power state of a two-core package. Each cycle it reads a 3-bit idle-state code from each core, a stop-clock request pin and a one-cycle marker for the response phase of the bus acknowledge that answers a stop-clock request. From these it reports one of three package states: Normal, Stop-Grant or Deeper Sleep. It also drives a per-core signal that forces a core into Stop-Grant and a request to enter Deeper Sleep. Each core's idle code is captured when stop-clock is first seen, so that when stop-clock is released the core can be told which state to resume.

A controller state machine has five states:
- RUN is the normal operating state.
- DEEP means Deeper Sleep has been granted.
- SG_WAIT means stop-clock is active and the acknowledge has not yet been seen.
- SG_TIMED means the acknowledge has been seen and the deadline counter is running.
- SG_SETTLED means every affected core is in Stop-Grant, or the deadline has passed.

The transitions are:
- RUN→SG_WAIT and DEEP→SG_WAIT on stop-clock.
- RUN→DEEP when the sleep condition holds.
- DEEP→RUN as soon as the sleep condition fails.
- SG_WAIT→SG_TIMED on the acknowledge.
- SG_TIMED→SG_SETTLED when the cores are done or the deadline expires.
- Any Stop-Grant state→RUN when stop-clock drops.

Stop-clock takes priority over sleep. A single-core mode ignores the second core completely. In that mode a lone core reaching C4 may only request Deeper Sleep when a coordination enable is set.

Top module: `pkg_lp_coord`

## Requirements
- R1: Core codes are C0=0, C1=1, C2=2, C3=3, C4=4 and Stop-Grant=5; codes 6 and 7 are treated as active. The package state output encodes Normal=0, Stop-Grant=1 and Deeper Sleep=2. While stop-clock is low and no sleep is granted, the package state is Normal. It is always Normal while stop-clock is low and an enabled core reports C0 or C1.
- R2: Once stop-clock has been sampled high on a rising edge, and for as long as it stays high, the package state is Stop-Grant. The force bit of each eligible core is asserted during that time.
- R3: Each enabled core's code is captured on the first edge at which stop-clock is sampled high. A core whose captured code is C2, C3 or C4 is not eligible, and its force bit stays low. Later changes to a core's code while stop-clock stays high change neither the captured code nor the force bits.
- R4: In every cycle where stop-clock is low while the controller is in a Stop-Grant state, the following hold:
  - the resume strobe is high and both resume codes show the captured codes;
  - the force bits are low;
  - the package state is not Stop-Grant.
  The strobe is low one edge later.
- R5: The deadline counter starts at the edge where the acknowledge marker is sampled in SG_WAIT, and it counts bus clocks after that edge. If some eligible core still does not report code 5 when the count reaches 20, the late flag rises one edge later, and not earlier. The flag stays set until stop-clock drops. If all eligible cores report 5 by the 20th edge, the flag stays low.
- R6: In dual-core mode with sleep enabled, both cores reporting C4 raises the sleep request one edge later, and the package state becomes Deeper Sleep. If only one core is in C4, there is no request.
- R7: In single-core mode, the sleep request needs three things: core 0 in C4, the coordination enable and the sleep enable. The code of core 1, its force bit and its Stop-Grant report are all ignored.
- R8: The sleep request and the Deeper Sleep state drop in the same cycle that a relevant core leaves C4, with no edge in between.
- R9: With the sleep enable low, no sleep request is ever made.
- R10: While reset is held, all of the following are zero: package state, force bits, sleep request, late flag and resume strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| core0_code | input | 3 | Idle-state code of core 0 |
| core1_code | input | 3 | Idle-state code of core 1 |
| stop_clk | input | 1 | Stop-clock request, active high |
| ack_phase | input | 1 | Response phase of the stop-clock acknowledge cycle |
| cfg_single | input | 1 | Single-core mode |
| cfg_coord_en | input | 1 | Allow a lone core in C4 to request sleep |
| cfg_deep_en | input | 1 | Package deep sleep enable |
| pkg_state | output | 2 | Package power state |
| force_sg | output | 2 | Per-core forced Stop-Grant |
| deep_req | output | 1 | Deeper Sleep request |
| ack_late | output | 1 | Stop-Grant deadline missed |
| resume_vld | output | 1 | Restore strobe on stop-clock release |
| resume0_code | output | 3 | Code core 0 held before Stop-Grant |
| resume1_code | output | 3 | Code core 1 held before Stop-Grant |

## Verification
The sleep decision is driven by a table of mode, enable and core-code combinations. The table separates a pair of C4 cores from a single C4 core, an enabled path from a disabled one, and single-core from dual-core handling. Stop-clock runs separate an eligible core from one already in a deeper state, and they show that later code changes do not touch the captured codes. Deadline runs put the last Stop-Grant report on the 20th edge and also let the 21st edge pass without one, which sets the exact boundary of the late flag. A leave-C4 run shows that the request drops in the same cycle, before any edge.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    localparam int CODE_W = 3;
    localparam int NCORE  = 2;

    localparam logic [CODE_W-1:0] CS_C0 = 3'd0;
    localparam logic [CODE_W-1:0] CS_C1 = 3'd1;
    localparam logic [CODE_W-1:0] CS_C2 = 3'd2;
    localparam logic [CODE_W-1:0] CS_C3 = 3'd3;
    localparam logic [CODE_W-1:0] CS_C4 = 3'd4;
    localparam logic [CODE_W-1:0] CS_SG = 3'd5;

    typedef enum logic [1:0] {
        PKG_NORMAL    = 2'd0,
        PKG_STOPGRANT = 2'd1,
        PKG_DEEPER    = 2'd2
    } pkg_state_e;

    typedef enum logic [2:0] {
        F_RUN        = 3'd0,
        F_DEEP       = 3'd1,
        F_SG_WAIT    = 3'd2,
        F_SG_TIMED   = 3'd3,
        F_SG_SETTLED = 3'd4
    } fsm_e;
endpackage

// File: rtl/lpc_core_slot.sv
module lpc_core_slot
    import lpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] snap,
    output logic              eligible,
    output logic              at_sg,
    output logic              at_c4
);
    logic snap_deep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= CS_C0;
        end else if (capture) begin
            snap <= code_in;
        end
    end

    always_comb begin
        snap_deep = (snap == CS_C2) || (snap == CS_C3) || (snap == CS_C4);
        eligible  = enable && !snap_deep;
        at_sg     = enable && (code_in == CS_SG);
        at_c4     = enable && (code_in == CS_C4);
    end
endmodule

// File: rtl/lpc_ack_timer.sv
module lpc_ack_timer #(
    parameter int CNT_W = 5,
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LIM);
endmodule

// File: rtl/pkg_lp_coord.sv
module pkg_lp_coord
    import lpc_pkg::*;
#(
    parameter int ACK_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] core0_code,
    input  logic [CODE_W-1:0] core1_code,
    input  logic              stop_clk,
    input  logic              ack_phase,
    input  logic              cfg_single,
    input  logic              cfg_coord_en,
    input  logic              cfg_deep_en,
    output logic [1:0]        pkg_state,
    output logic [NCORE-1:0]  force_sg,
    output logic              deep_req,
    output logic              ack_late,
    output logic              resume_vld,
    output logic [CODE_W-1:0] resume0_code,
    output logic [CODE_W-1:0] resume1_code
);
    localparam int CNT_W = $clog2(ACK_LIMIT + 1);

    logic [CODE_W-1:0] code_in [NCORE];
    logic [CODE_W-1:0] snap    [NCORE];
    logic [NCORE-1:0]  slot_en, elig, at_sg, at_c4;

    fsm_e state_q, state_d;
    logic capture, timer_start, timer_run, expired;
    logic deep_cond, all_done, in_sg, late_q;

    assign code_in[0] = core0_code;
    assign code_in[1] = core1_code;

    generate
        for (genvar i = 0; i < NCORE; i++) begin : g_slot
            assign slot_en[i] = (i == 0) ? 1'b1 : !cfg_single;
            lpc_core_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .enable   (slot_en[i]),
                .capture  (capture),
                .code_in  (code_in[i]),
                .snap     (snap[i]),
                .eligible (elig[i]),
                .at_sg    (at_sg[i]),
                .at_c4    (at_c4[i])
            );
        end
    endgenerate

    lpc_ack_timer #(
        .CNT_W (CNT_W),
        .LIMIT (ACK_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (timer_start),
        .run     (timer_run),
        .expired (expired)
    );

    always_comb begin
        all_done  = &(~elig | at_sg);
        deep_cond = cfg_deep_en &&
                    (cfg_single ? (cfg_coord_en && at_c4[0]) : (at_c4[0] && at_c4[1]));
        in_sg     = (state_q == F_SG_WAIT) || (state_q == F_SG_TIMED) ||
                    (state_q == F_SG_SETTLED);
        capture     = stop_clk && ((state_q == F_RUN) || (state_q == F_DEEP));
        timer_start = (state_q == F_SG_WAIT) && stop_clk && ack_phase;
        timer_run   = (state_q == F_SG_TIMED);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_RUN: begin
                if (stop_clk)       state_d = F_SG_WAIT;
                else if (deep_cond) state_d = F_DEEP;
            end
            F_DEEP: begin
                if (stop_clk)        state_d = F_SG_WAIT;
                else if (!deep_cond) state_d = F_RUN;
            end
            F_SG_WAIT: begin
                if (!stop_clk)      state_d = F_RUN;
                else if (ack_phase) state_d = F_SG_TIMED;
            end
            F_SG_TIMED: begin
                if (!stop_clk)                state_d = F_RUN;
                else if (all_done || expired) state_d = F_SG_SETTLED;
            end
            F_SG_SETTLED: begin
                if (!stop_clk) state_d = F_RUN;
            end
            default: state_d = F_RUN;
        endcase
    end

    // state register and deadline flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= F_RUN;
            late_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (in_sg && !stop_clk) begin
                late_q <= 1'b0;
            end else if ((state_q == F_SG_TIMED) && expired && !all_done) begin
                late_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        force_sg     = (in_sg && stop_clk) ? elig : '0;
        resume_vld   = in_sg && !stop_clk;
        resume0_code = snap[0];
        resume1_code = snap[1];
        deep_req     = (state_q == F_DEEP) && deep_cond;
        ack_late     = late_q;
        if (in_sg && stop_clk)  pkg_state = PKG_STOPGRANT;
        else if (deep_req)      pkg_state = PKG_DEEPER;
        else                    pkg_state = PKG_NORMAL;
    end
endmodule

// File: rtl/lpc_checks.sv
module lpc_checks
    import lpc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] core0_code,
    input logic [CODE_W-1:0] core1_code,
    input logic              stop_clk,
    input logic              cfg_single,
    input logic              cfg_coord_en,
    input logic              cfg_deep_en,
    input logic [1:0]        pkg_state,
    input logic [NCORE-1:0]  force_sg,
    input logic              deep_req,
    input logic              ack_late,
    input logic              resume_vld
);
    logic stop_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stop_seen_q <= 1'b0;
        else        stop_seen_q <= stop_clk;
    end

    p_normal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_clk && (core0_code == CS_C0 || core0_code == CS_C1))
        |-> pkg_state == PKG_NORMAL);

    p_stopgrant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_clk && stop_seen_q) |-> pkg_state == PKG_STOPGRANT);

    p_force_needs_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (force_sg != '0) |-> (stop_clk && stop_seen_q));

    p_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vld |-> (!stop_clk && force_sg == '0 && pkg_state != PKG_STOPGRANT));

    p_late_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_late && stop_clk) |=> ack_late);

    p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_req && !cfg_single) |-> (core0_code == CS_C4 && core1_code == CS_C4));

    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_req && cfg_single) |-> (cfg_coord_en && core0_code == CS_C4));

    p_single_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_single |-> !force_sg[1]);

    p_deep_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkg_state == PKG_DEEPER) |-> deep_req);

    p_no_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_deep_en |-> !deep_req);
endmodule

bind pkg_lp_coord lpc_checks u_lpc_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .core0_code   (core0_code),
    .core1_code   (core1_code),
    .stop_clk     (stop_clk),
    .cfg_single   (cfg_single),
    .cfg_coord_en (cfg_coord_en),
    .cfg_deep_en  (cfg_deep_en),
    .pkg_state    (pkg_state),
    .force_sg     (force_sg),
    .deep_req     (deep_req),
    .ack_late     (ack_late),
    .resume_vld   (resume_vld)
);

// File: tb/tb_pkg_lp_coord.sv
module tb_pkg_lp_coord;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] core0_code = 3'd0, core1_code = 3'd0;
    logic       stop_clk = 1'b0, ack_phase = 1'b0;
    logic       cfg_single = 1'b0, cfg_coord_en = 1'b0, cfg_deep_en = 1'b0;
    logic [1:0] pkg_state, force_sg;
    logic       deep_req, ack_late, resume_vld;
    logic [2:0] resume0_code, resume1_code;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkg_lp_coord dut (
        .clk(clk), .rst_n(rst_n), .core0_code(core0_code), .core1_code(core1_code),
        .stop_clk(stop_clk), .ack_phase(ack_phase), .cfg_single(cfg_single),
        .cfg_coord_en(cfg_coord_en), .cfg_deep_en(cfg_deep_en), .pkg_state(pkg_state),
        .force_sg(force_sg), .deep_req(deep_req), .ack_late(ack_late),
        .resume_vld(resume_vld), .resume0_code(resume0_code), .resume1_code(resume1_code)
    );

    // {single, coord, deep_en, c0[2:0], c1[2:0], exp_deep, exp_pkg[1:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b1, 3'd4, 3'd4, 1'b1, 2'd2},  // R6 both C4
        {1'b0, 1'b0, 1'b1, 3'd4, 3'd3, 1'b0, 2'd0},  // R6 one C4 only
        {1'b0, 1'b0, 1'b0, 3'd4, 3'd4, 1'b0, 2'd0},  // R9 enable low
        {1'b1, 1'b1, 1'b1, 3'd4, 3'd0, 1'b1, 2'd2},  // R7 lone core, coordination on
        {1'b1, 1'b0, 1'b1, 3'd4, 3'd4, 1'b0, 2'd0},  // R7 coordination off
        {1'b0, 1'b0, 1'b1, 3'd0, 3'd4, 1'b0, 2'd0},  // R1 core in C0
        {1'b1, 1'b1, 1'b1, 3'd1, 3'd4, 1'b0, 2'd0},  // R7 core 1 ignored
        {1'b0, 1'b1, 1'b1, 3'd2, 3'd2, 1'b0, 2'd0}   // R1 both C2, Normal
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        // R10 reset values
        tick(3);
        check("R10 pkg_state", pkg_state, 0);
        check("R10 force_sg", force_sg, 0);
        check("R10 deep_req", deep_req, 0);
        check("R10 ack_late", ack_late, 0);
        check("R10 resume_vld", resume_vld, 0);
        rst_n = 1'b1;
        tick(1);

        // table walk: sleep decision (R1 R6 R7 R9)
        for (int k = 0; k < NVEC; k++) begin
            {cfg_single, cfg_coord_en, cfg_deep_en, core0_code, core1_code} = VEC[k][11:3];
            tick(2);
            check($sformatf("table row %0d deep_req", k), deep_req, int'(VEC[k][2]));
            check($sformatf("table row %0d pkg_state", k), pkg_state, int'(VEC[k][1:0]));
        end

        // R8: same-cycle drop on leaving C4
        cfg_single = 0; cfg_coord_en = 0; cfg_deep_en = 1;
        core0_code = 3'd4; core1_code = 3'd4;
        tick(2);
        check("R8 deep before exit", deep_req, 1);
        core1_code = 3'd3;
        #1;
        check("R8 deep_req drops same cycle", deep_req, 0);
        check("R8 pkg leaves Deeper Sleep", pkg_state, 0);
        tick(1);
        check("R8 stays Normal", pkg_state, 0);
        cfg_deep_en = 0;

        // R2 R3 R4 R5: stop-clock with one core already in C3
        core0_code = 3'd0; core1_code = 3'd3;
        tick(1);
        stop_clk = 1;
        tick(1);
        check("R2 pkg Stop-Grant", pkg_state, 1);
        check("R3 force only eligible core", force_sg, 1);
        core1_code = 3'd0;
        tick(1);
        check("R3 later code change ignored", force_sg, 1);
        ack_phase = 1;
        tick(1);
        ack_phase = 0;
        tick(4);
        core0_code = 3'd5;
        tick(25);
        check("R5 no late flag when in time", ack_late, 0);
        stop_clk = 0;
        #1;
        check("R4 resume strobe", resume_vld, 1);
        check("R4 resume code core0", resume0_code, 0);
        check("R4 resume code core1", resume1_code, 3);
        check("R4 force released", force_sg, 0);
        check("R4 pkg not Stop-Grant", pkg_state, 0);
        tick(1);
        check("R4 strobe one cycle", resume_vld, 0);

        // R5: deadline missed, boundary 20 versus 21 edges
        core0_code = 3'd0; core1_code = 3'd0;
        tick(1);
        stop_clk = 1;
        tick(1);
        check("R2 both cores forced", force_sg, 3);
        ack_phase = 1;
        tick(1);
        ack_phase = 0;
        tick(20);
        check("R5 not late at count 20", ack_late, 0);
        tick(1);
        check("R5 late one edge after count 20", ack_late, 1);
        tick(3);
        check("R5 late flag sticky", ack_late, 1);
        stop_clk = 0;
        tick(1);
        check("R5 late cleared on release", ack_late, 0);

        // R5: last report lands on the 20th edge
        stop_clk = 1;
        tick(1);
        ack_phase = 1;
        tick(1);
        ack_phase = 0;
        tick(19);
        core0_code = 3'd5; core1_code = 3'd5;
        tick(4);
        check("R5 report on 20th edge in time", ack_late, 0);
        stop_clk = 0;
        core0_code = 3'd0; core1_code = 3'd0;
        tick(2);

        // R7: single-core mode with stop-clock ignores core 1
        cfg_single = 1;
        core1_code = 3'd0;
        stop_clk = 1;
        tick(1);
        check("R7 core1 never forced", force_sg, 1);
        ack_phase = 1;
        tick(1);
        ack_phase = 0;
        core0_code = 3'd5;
        tick(3);
        check("R7 core1 report not needed", ack_late, 0);
        stop_clk = 0;
        tick(1);
        check("R1 back to Normal", pkg_state, 0);

        summary();
    end
endmodule